// File: doc/BRIEF.md
# Selectable GPIO Interrupt Slot Bank

This block turns a wide vector of GPIO interrupt lines into a fixed set of interrupt slots. Software assigns any GPIO line to any slot. Each slot has its own enable, sense mode, edge status and mask, and drives one active-high interrupt output towards a parent interrupt controller. GPIO inputs pass through a synchronizer before a slot sees them. In the edge modes a slot latches an event in a status bit that software clears. In the level modes the output follows the synchronized input at the programmed polarity.

Software programs the bank over a simple 32-bit register bus. Write data is taken on the clock edge where the write enable is high. Read data appears on the read data port one clock after the read enable. To reassign a slot, software first drops that slot's enable, then writes the new source, clears the stale status, and finally sets the enable again. While a slot is disabled it tracks its selected input without reporting events, so changing the source does not produce a false edge.

Top module: `gpio_irq_slot_bank`

## Requirements
- R1: Slot n's select byte sits in the register at 0x30 + 4*(n/4), in bits 8*(n%4)+7 down to 8*(n%4). Bits 6:0 of the byte hold the source GPIO number and bit 7 is the slot enable. A read returns what was written, one cycle after the read enable. An unmapped address reads 0.
- R2: Slot n's 2-bit sense field is in the register at 0x24 for slots 0 to 15 and at 0x28 for slots 16 to 31, in bits 2*(n%16)+1 down to 2*(n%16). The codes are 0 = rising edge, 1 = falling edge, 2 = level high, 3 = level low.
- R3: In rising mode, an enabled slot sets its status bit n in the register at 0x20 when its synchronized source goes from 0 to 1. Its output is high while that bit is set, the slot is enabled and the slot is unmasked.
- R4: In falling mode, an enabled slot sets its status bit on a 1-to-0 change of its source and ignores a 0-to-1 change.
- R5: A slot whose enable is 0 never sets its status bit. Setting the enable while the source is steady creates no event.
- R6: Writing 0x20 clears every latched status bit whose written bit is 0. Bits written as 1 are left unchanged.
- R7: In the level modes the output and status bit n follow the input: active on 1 in mode 2 and on 0 in mode 3. Nothing is latched, so a status clear write has no effect.
- R8: When an edge is detected in the same cycle as a clear write to its status bit, the status bit stays set.
- R9: Bit n of the mask register at 0x50 forces output n low when it is 1. The status bit still latches.
- R10: A source number of NUM_GPIO or more selects a constant 0 input.
- R11: After reset, all select bytes, sense fields, status bits and mask bits read 0, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 8 | Byte address of the register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid one cycle after busRdEn |
| gpioIn | input | NUM_GPIO | Asynchronous GPIO interrupt lines |
| irqOut | output | NUM_SLOTS | Active-high interrupt per slot |

## Verification
The bench builds the bank with all 32 slots, so both sense registers and all eight select registers are in use, and with NUM_GPIO set to 20. The narrower GPIO width brings source numbers 20 to 127 within reach of the 7-bit source field. The bench can then check both the constant-0 behaviour just past the last line and a correct pick of line 19. The two-stage synchronizer sets a fixed latency from an input change to status. The bench uses that latency to line up an edge with a status clear write in exactly the same cycle.

// File: rtl/gsb_pkg.sv
package gsb_pkg;
  localparam int BUS_W = 32;
  localparam int SRC_W = 7;
  localparam int SRC_SPAN = 1 << SRC_W;

  localparam logic [7:0] ADDR_STATUS  = 8'h20;
  localparam logic [7:0] ADDR_SENSE   = 8'h24;
  localparam logic [7:0] ADDR_SELECT  = 8'h30;
  localparam logic [7:0] ADDR_MASK    = 8'h50;

  typedef enum logic [1:0] {
    SENSE_RISE = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_HIGH = 2'd2,
    SENSE_LOW  = 2'd3
  } sense_e;

  typedef struct packed {
    logic             statusWr;
    logic [BUS_W-1:0] wrData;
  } strobe_t;
endpackage

// File: rtl/gsb_ctrl.sv
module gsb_ctrl
  import gsb_pkg::*;
#(
  parameter int NUM_SLOTS = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wrEn,
  input  logic                       rdEn,
  input  logic [7:0]                 addr,
  input  logic [BUS_W-1:0]           wrData,
  input  logic [NUM_SLOTS-1:0]       statusView,
  output logic [BUS_W-1:0]           rdData,
  output strobe_t                    strobe,
  output logic [NUM_SLOTS-1:0]       slotEn,
  output logic [NUM_SLOTS*SRC_W-1:0] slotSrc,
  output logic [NUM_SLOTS*2-1:0]     slotSense,
  output logic [NUM_SLOTS-1:0]       slotMask
);
  logic [7:0]     selByte [NUM_SLOTS];
  logic [1:0]     senseFld[NUM_SLOTS];
  logic [BUS_W-1:0] rdNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < NUM_SLOTS; n++) begin
        selByte[n]  <= '0;
        senseFld[n] <= '0;
        slotMask[n] <= 1'b0;
      end
    end else if (wrEn) begin
      for (int n = 0; n < NUM_SLOTS; n++) begin
        if (addr == 8'(ADDR_SELECT + 4 * (n / 4)))
          selByte[n] <= wrData[8 * (n % 4) +: 8];
        if (addr == 8'(ADDR_SENSE + 4 * (n / 16)))
          senseFld[n] <= wrData[2 * (n % 16) +: 2];
        if (addr == ADDR_MASK)
          slotMask[n] <= wrData[n];
      end
    end
  end

  always_comb begin
    rdNext = '0;
    for (int n = 0; n < NUM_SLOTS; n++) begin
      if (addr == 8'(ADDR_SELECT + 4 * (n / 4)))
        rdNext[8 * (n % 4) +: 8] = selByte[n];
      if (addr == 8'(ADDR_SENSE + 4 * (n / 16)))
        rdNext[2 * (n % 16) +: 2] = senseFld[n];
      if (addr == ADDR_MASK)
        rdNext[n] = slotMask[n];
      if (addr == ADDR_STATUS)
        rdNext[n] = statusView[n];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       rdData <= '0;
    else if (rdEn) rdData <= rdNext;
  end

  assign strobe.statusWr = wrEn && (addr == ADDR_STATUS);
  assign strobe.wrData   = wrData;

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_out
    assign slotEn[n]                   = selByte[n][7];
    assign slotSrc[n*SRC_W +: SRC_W]   = selByte[n][SRC_W-1:0];
    assign slotSense[2*n +: 2]         = senseFld[n];
  end

  // R11: configuration is clear on the first cycle after reset
  a_r11_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (slotEn == '0 && slotMask == '0 && slotSense == '0));
endmodule

// File: rtl/gsb_datapath.sv
module gsb_datapath
  import gsb_pkg::*;
#(
  parameter int NUM_SLOTS   = 32,
  parameter int NUM_GPIO    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_GPIO-1:0]        gpioIn,
  input  strobe_t                    strobe,
  input  logic [NUM_SLOTS-1:0]       slotEn,
  input  logic [NUM_SLOTS*SRC_W-1:0] slotSrc,
  input  logic [NUM_SLOTS*2-1:0]     slotSense,
  input  logic [NUM_SLOTS-1:0]       slotMask,
  output logic [NUM_SLOTS-1:0]       statusView,
  output logic [NUM_SLOTS-1:0]       irqOut
);
  logic [NUM_GPIO-1:0] syncStage[SYNC_STAGES];
  logic [SRC_SPAN-1:0] srcPool;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncStage[s] <= '0;
    end else begin
      syncStage[0] <= gpioIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncStage[s] <= syncStage[s-1];
    end
  end

  // lines past NUM_GPIO are zero-filled, giving a constant 0 source
  assign srcPool = SRC_SPAN'(syncStage[SYNC_STAGES-1]);

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
    logic [SRC_W-1:0] src;
    sense_e mode;
    logic selBit, prevBit, edgeHit, clrHit, levelMode, levelAct, edgeLatch;

    assign src       = slotSrc[n*SRC_W +: SRC_W];
    assign mode      = sense_e'(slotSense[2*n +: 2]);
    assign selBit    = srcPool[src];
    assign levelMode = mode[1];
    assign clrHit    = strobe.statusWr && !strobe.wrData[n];

    // history always follows the selected line, so a disabled slot reloads it
    always_ff @(posedge clk) begin
      if (rst) prevBit <= 1'b0;
      else     prevBit <= selBit;
    end

    always_comb begin
      edgeHit = 1'b0;
      if (slotEn[n]) begin
        if (mode == SENSE_RISE) edgeHit = selBit && !prevBit;
        if (mode == SENSE_FALL) edgeHit = !selBit && prevBit;
      end
      levelAct = slotEn[n] &&
                 ((mode == SENSE_HIGH && selBit) || (mode == SENSE_LOW && !selBit));
    end

    always_ff @(posedge clk) begin
      if (rst || levelMode) edgeLatch <= 1'b0;
      else                  edgeLatch <= edgeHit || (edgeLatch && !clrHit);
    end

    assign statusView[n] = levelMode ? levelAct : edgeLatch;
    assign irqOut[n]     = statusView[n] && slotEn[n] && !slotMask[n];

    // R5: a status bit only rises after a cycle with the slot enabled
    a_r5_no_event_disabled: assert property (@(posedge clk) disable iff (rst)
      $rose(edgeLatch) |-> $past(slotEn[n]));
    // R8: a detected edge beats a simultaneous clear
    a_r8_edge_wins: assert property (@(posedge clk) disable iff (rst)
      (edgeHit && clrHit) |=> edgeLatch);
    // R7: level modes never leave anything latched
    a_r7_level_no_latch: assert property (@(posedge clk) disable iff (rst)
      levelMode |=> !edgeLatch);
    // R9: a masked slot keeps its output low
    a_r9_mask_gates: assert property (@(posedge clk) disable iff (rst)
      slotMask[n] |-> !irqOut[n]);
  end
endmodule

// File: rtl/gpio_irq_slot_bank.sv
module gpio_irq_slot_bank
  import gsb_pkg::*;
#(
  parameter int NUM_SLOTS   = 32,
  parameter int NUM_GPIO    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  input  logic [7:0]           busAddr,
  input  logic [31:0]          busWrData,
  output logic [31:0]          busRdData,
  input  logic [NUM_GPIO-1:0]  gpioIn,
  output logic [NUM_SLOTS-1:0] irqOut
);
  strobe_t                    strobe;
  logic [NUM_SLOTS-1:0]       slotEn, slotMask, statusView;
  logic [NUM_SLOTS*SRC_W-1:0] slotSrc;
  logic [NUM_SLOTS*2-1:0]     slotSense;

  gsb_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(busWrEn), .rdEn(busRdEn), .addr(busAddr),
    .wrData(busWrData), .statusView(statusView), .rdData(busRdData),
    .strobe(strobe), .slotEn(slotEn), .slotSrc(slotSrc),
    .slotSense(slotSense), .slotMask(slotMask)
  );

  gsb_datapath #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_GPIO(NUM_GPIO), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rst(rst), .gpioIn(gpioIn), .strobe(strobe), .slotEn(slotEn),
    .slotSrc(slotSrc), .slotSense(slotSense), .slotMask(slotMask),
    .statusView(statusView), .irqOut(irqOut)
  );
endmodule

// File: tb/gpio_irq_slot_bank_tb.sv
module gpio_irq_slot_bank_tb;
  localparam int NS = 32;
  localparam int NG = 20;

  logic clk = 0, rst = 1;
  logic busWrEn = 0, busRdEn = 0;
  logic [7:0] busAddr = 0;
  logic [31:0] busWrData = 0, busRdData;
  logic [NG-1:0] gpioIn = '0;
  logic [NS-1:0] irqOut;
  int nChk = 0, nBad = 0;
  logic [31:0] rd;

  gpio_irq_slot_bank #(.NUM_SLOTS(NS), .NUM_GPIO(NG)) u_dut (
    .clk(clk), .rst(rst), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .gpioIn(gpioIn), .irqOut(irqOut)
  );

  always #10 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); busWrEn = 1; busAddr = a; busWrData = d;
    @(negedge clk); busWrEn = 0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); busRdEn = 1; busAddr = a;
    @(negedge clk); busRdEn = 0; d = busRdData;
  endtask

  task automatic t_reset;
    logic [7:0] regs[6] = '{8'h20, 8'h24, 8'h28, 8'h30, 8'h4C, 8'h50};
    foreach (regs[i]) begin
      rdReg(regs[i], rd);
      chk(rd == 0, "R11 reset register", rd, 0);
    end
    chk(irqOut == 0, "R11 reset outputs", irqOut, 0);
    rdReg(8'h60, rd);
    chk(rd == 0, "R1 unmapped reads 0", rd, 0);
  endtask

  task automatic t_rise_clear;
    wr(8'h34, 32'h0000_8300);
    rdReg(8'h34, rd);
    chk(rd == 32'h0000_8300, "R1 select readback", rd, 32'h0000_8300);
    gpioIn[3] = 1; tick(4);
    rdReg(8'h20, rd);
    chk(rd[5] == 1, "R3 rising sets status", rd, 32'h20);
    chk(irqOut[5] == 1, "R3 irq high", irqOut, 32'h20);
    wr(8'h20, 32'hFFFF_FFFF);
    rdReg(8'h20, rd);
    chk(rd[5] == 1, "R6 write 1 no effect", rd, 32'h20);
    wr(8'h20, ~32'h20);
    rdReg(8'h20, rd);
    chk(rd[5] == 0, "R6 write 0 clears", rd, 0);
    chk(irqOut[5] == 0, "R6 irq drops", irqOut, 0);
  endtask

  task automatic t_edge_wins;
    gpioIn[3] = 0; tick(4);
    gpioIn[3] = 1;
    @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
    busWrEn = 1; busAddr = 8'h20; busWrData = ~32'h20;
    @(negedge clk); busWrEn = 0;
    rdReg(8'h20, rd);
    chk(rd[5] == 1, "R8 edge beats clear", rd, 32'h20);
  endtask

  task automatic t_mask;
    wr(8'h50, 32'h20); tick(1);
    chk(irqOut[5] == 0, "R9 masked irq low", irqOut, 0);
    rdReg(8'h20, rd);
    chk(rd[5] == 1, "R9 status kept under mask", rd, 32'h20);
    wr(8'h50, 32'h0); tick(1);
    chk(irqOut[5] == 1, "R9 unmasked irq high", irqOut, 32'h20);
    wr(8'h20, 32'h0);
  endtask

  task automatic t_falling;
    wr(8'h44, 32'h87);
    wr(8'h28, 32'h100);
    rdReg(8'h28, rd);
    chk(rd == 32'h100, "R2 sense high register readback", rd, 32'h100);
    gpioIn[7] = 1; tick(4);
    rdReg(8'h20, rd);
    chk(rd[20] == 0, "R4 rising ignored in falling mode", rd, 0);
    gpioIn[7] = 0; tick(4);
    rdReg(8'h20, rd);
    chk(rd[20] == 1, "R4 falling sets status", rd, 32'h0010_0000);
    chk(irqOut[20] == 1, "R4 irq high", irqOut, 32'h0010_0000);
    wr(8'h20, 32'h0);
    wr(8'h44, 32'h0);
  endtask

  task automatic t_disabled;
    wr(8'h30, 32'h0006_0000);
    gpioIn[6] = 1; tick(4);
    rdReg(8'h20, rd);
    chk(rd[2] == 0, "R5 disabled slot ignores edge", rd, 0);
    wr(8'h30, 32'h0086_0000); tick(4);
    rdReg(8'h20, rd);
    chk(rd[2] == 0, "R5 enable on steady input no event", rd, 0);
    gpioIn[6] = 0; tick(4); gpioIn[6] = 1; tick(4);
    rdReg(8'h20, rd);
    chk(rd[2] == 1, "R5 enabled slot sees edge", rd, 32'h4);
    wr(8'h20, 32'h0);
    wr(8'h30, 32'h0);
  endtask

  task automatic t_level;
    wr(8'h38, 32'h0000_8400);
    wr(8'h24, 32'h0008_0000);
    gpioIn[4] = 1; tick(4);
    chk(irqOut[9] == 1, "R7 level high active", irqOut, 32'h200);
    rdReg(8'h20, rd);
    chk(rd[9] == 1, "R7 status live", rd, 32'h200);
    gpioIn[4] = 0; tick(4);
    chk(irqOut[9] == 0, "R7 level high follows low", irqOut, 0);
    rdReg(8'h20, rd);
    chk(rd[9] == 0, "R7 status not latched", rd, 0);
    wr(8'h24, 32'h000C_0000); tick(1);
    chk(irqOut[9] == 1, "R7 level low active on 0", irqOut, 32'h200);
    wr(8'h20, 32'h0);
    rdReg(8'h20, rd);
    chk(rd[9] == 1, "R7 clear has no effect in level mode", rd, 32'h200);
    wr(8'h38, 32'h0);
    wr(8'h24, 32'h0);
  endtask

  task automatic t_range;
    wr(8'h3C, 32'h99);
    wr(8'h24, 32'h0200_0000); tick(4);
    chk(irqOut[12] == 0, "R10 out-of-range source is 0", irqOut, 0);
    gpioIn = '1; tick(4);
    chk(irqOut[12] == 0, "R10 out-of-range ignores inputs", irqOut, 0);
    wr(8'h3C, 32'h93); tick(1);
    chk(irqOut[12] == 1, "R10 last in-range line selected", irqOut, 32'h1000);
    wr(8'h3C, 32'h14); tick(1);
    chk(irqOut[12] == 0, "R10 disabled level slot low", irqOut, 0);
  endtask

  initial begin
    fork
      begin
        tick(3); rst = 0; tick(1);
        t_reset();
        t_rise_clear();
        t_edge_wins();
        t_mask();
        t_falling();
        t_disabled();
        t_level();
        t_range();
      end
      begin
        repeat (20000) @(posedge clk);
        nChk++; nBad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule